// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status word that a parallel NOR flash places on its data lines while an internal program, erase or buffered-write algorithm runs. The surrounding flash model supplies the current operating mode and whether the read address falls in the sector the operation works on. It also supplies the true value of the word being written, a read strobe that marks each completed read access, and event pulses for a time-limit overrun and for an aborted buffered write. From these the block drives six status bits. It also drives a select that tells the data-path mux to pass ordinary array data instead, an active-low ready/busy line, and an error flag for a read the device does not allow.

Two status bits toggle on read accesses. The busy-toggle bit is `st_dq6` and the erase-toggle bit is `st_dq2`. Each is backed by a flop that flips once per read strobe in the modes where it toggles, and holds its value in the other modes. Both flops clear when a new operation starts. The time-limit flag and the abort flag are sticky. Once set, they stay set until the reset input or a flag-clear command clears them.

Mode encoding on `op_mode`: 0 array read, 1 program, 2 erase, 3 erase-suspend read, 4 program-suspend read, 5 erase-suspend-program, 6 buffered-write busy, 7 array read. Modes 1, 2, 5 and 6 are the busy modes.

Top module: `nor_status_gen`

## Requirements
- R1: After reset, and in modes 0 and 7, `array_sel` is 1, `ready_n` is 1, and all six status bits and `illegal_rd` are 0.
- R2: In mode 1 (program), `st_dq7` is the complement of bit 7 of `wr_data`. `st_dq6` flips after every read strobe. `st_dq2` does not change over read strobes. `st_dq3` and `st_dq1` are 0 and `ready_n` is 0.
- R3: In mode 2 (erase), `st_dq7` is 0 and `st_dq3` is 1. `st_dq6` and `st_dq2` both flip after every read strobe, and `ready_n` is 0.
- R4: In mode 3 with `in_susp_sector`=1, `st_dq7` is 1 and `st_dq5` is 0. `st_dq6` holds its value across read strobes, `st_dq2` flips after every read strobe, and `ready_n` is 1.
- R5: In mode 3 or mode 4 with `in_susp_sector`=0, `array_sel` is 1, `ready_n` is 1 and all status bits are 0.
- R6: In modes 5 and 6, `st_dq7` is the complement of bit 7 of `wr_data`, `st_dq6` flips after every read strobe, and `ready_n` is 0.
- R7: An `abort_evt` pulse in mode 6 sets a sticky abort flag, which `st_dq1` shows only in mode 6. In mode 6 with no abort, `st_dq1` is 0. An `abort_evt` pulse in any other mode has no effect.
- R8: A `timeout_evt` pulse in a busy mode sets a sticky flag that `st_dq5` shows in every busy mode. The flag persists after the pulse. A `flag_clr` pulse clears it, and `flag_clr` wins over a simultaneous event.
- R9: An `op_start` pulse clears both toggle flops. It takes priority over a read strobe in the same cycle.
- R10: In mode 4 with `in_susp_sector`=1, `illegal_rd` is 1, all status bits are 0, `array_sel` is 0 and `ready_n` is 1.
- R11: Driving `rst_n` low clears the timeout and abort flags and both toggle flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_mode | input | 3 | Operating mode code |
| in_susp_sector | input | 1 | Read address lies in the suspended or active sector |
| wr_data | input | DATA_W | True value of the word being written |
| rd_strobe | input | 1 | One-cycle pulse per completed read access |
| op_start | input | 1 | One-cycle pulse when an embedded operation begins |
| timeout_evt | input | 1 | Time-limit overrun event |
| abort_evt | input | 1 | Buffered-write abort event |
| flag_clr | input | 1 | Flag-clear command pulse |
| st_dq7 | output | 1 | Data-polling bit |
| st_dq6 | output | 1 | Busy-toggle bit |
| st_dq5 | output | 1 | Time-limit exceeded bit |
| st_dq3 | output | 1 | Erase-in-progress bit |
| st_dq2 | output | 1 | Erase-toggle bit |
| st_dq1 | output | 1 | Buffered-write abort bit |
| array_sel | output | 1 | Pass array data instead of status |
| ready_n | output | 1 | Active-low ready/busy (0 = busy) |
| illegal_rd | output | 1 | Read of a program-suspended sector |

## Verification
The assertions take `rd_strobe`, `op_start`, `timeout_evt`, `abort_evt` and `flag_clr` to be synchronous single-cycle pulses. They also take `op_mode` and `in_susp_sector` to change only between clock edges, which holds because the bench drives all inputs on the falling edge. The toggle-step properties assume that no `op_start` arrives together with a read strobe unless that overlap is itself the case being checked. The bench issues `op_start` on its own in every scenario except the dedicated R9 priority case. It also keeps the mode fixed across each run of read strobes, so that every observed flip comes from a single mode's rule.

// File: rtl/nsg_pkg.sv
// Shared mode encoding and helper functions for the status generator.
// Assumes a 3-bit mode code driven by the surrounding flash model.
package nsg_pkg;

    typedef enum logic [2:0] {
        M_ARRAY  = 3'd0,
        M_PGM    = 3'd1,
        M_ERASE  = 3'd2,
        M_ESUSP  = 3'd3,
        M_PSUSP  = 3'd4,
        M_ESPGM  = 3'd5,
        M_WBUF   = 3'd6,
        M_ARRAY2 = 3'd7
    } op_mode_e;

    localparam int NUM_TOG  = 2;  // index 0: busy toggle, index 1: erase toggle
    localparam int NUM_FLAG = 2;  // index 0: time-limit, index 1: abort
    localparam int TOG_BUSY = 0;
    localparam int TOG_ERS  = 1;
    localparam int FLG_TO   = 0;
    localparam int FLG_AB   = 1;

    // True for modes in which an embedded algorithm is running.
    function automatic logic is_busy(input op_mode_e m);
        return (m == M_PGM) || (m == M_ERASE) || (m == M_ESPGM) || (m == M_WBUF);
    endfunction

endpackage

// File: rtl/nsg_toggle.sv
// Bank of read-access toggle flops.
// Each bit flips on a read strobe while its enable is high, and holds otherwise.
// A start pulse clears every bit and wins over a strobe in the same cycle.
// Assumes rd_strobe is one cycle wide per completed access.
module nsg_toggle #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         rd_strobe,
    input  logic [N-1:0] tog_en,
    output logic [N-1:0] tog_q
);

    for (genvar i = 0; i < N; i++) begin : g_tog
        // Advance one toggle bit per qualifying read access.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tog_q[i] <= 1'b0;
            end else if (start) begin
                tog_q[i] <= 1'b0;
            end else if (rd_strobe && tog_en[i]) begin
                tog_q[i] <= ~tog_q[i];
            end
        end
    end

endmodule

// File: rtl/nsg_sticky.sv
// Bank of sticky event flags.
// A flag sets on its qualified event and stays set until reset or a clear command.
// The clear command has priority over a simultaneous event.
module nsg_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flag_q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold each flag once set; clear on reset or clear command.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (clr) begin
                flag_q[i] <= 1'b0;
            end else if (set[i]) begin
                flag_q[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/nsg_decode.sv
// Combinational status decode.
// Maps the mode, the sector select, the toggle state and the flags onto the
// status bits, the array select, ready/busy and the illegal-read flag.
// It also computes the toggle enables and the flag set qualifiers.
// Holds no state.
module nsg_decode
    import nsg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int POLL_BIT = 7
) (
    input  op_mode_e            mode,
    input  logic                in_susp,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_TOG-1:0]  tog_q,
    input  logic [NUM_FLAG-1:0] flag_q,
    input  logic                timeout_evt,
    input  logic                abort_evt,
    output logic [NUM_TOG-1:0]  tog_en,
    output logic [NUM_FLAG-1:0] flag_set,
    output logic                dq7,
    output logic                dq6,
    output logic                dq5,
    output logic                dq3,
    output logic                dq2,
    output logic                dq1,
    output logic                array_sel,
    output logic                ready_n,
    output logic                illegal_rd
);

    logic poll_n;
    assign poll_n = ~wr_data[POLL_BIT];

    // Decide which toggle flops advance on a read in the current mode.
    always_comb begin
        tog_en = '0;
        tog_en[TOG_BUSY] = is_busy(mode);
        tog_en[TOG_ERS]  = (mode == M_ERASE) || ((mode == M_ESUSP) && in_susp);
    end

    // Qualify the event inputs by mode before they reach the sticky flags.
    always_comb begin
        flag_set = '0;
        flag_set[FLG_TO] = timeout_evt && is_busy(mode);
        flag_set[FLG_AB] = abort_evt && (mode == M_WBUF);
    end

    // Per-mode status word, array select and ready/busy.
    always_comb begin
        dq7 = 1'b0; dq6 = 1'b0; dq5 = 1'b0; dq3 = 1'b0; dq2 = 1'b0; dq1 = 1'b0;
        array_sel  = 1'b0;
        ready_n    = 1'b1;
        illegal_rd = 1'b0;
        unique case (mode)
            M_PGM: begin
                dq7 = poll_n;
                dq6 = tog_q[TOG_BUSY];
                dq5 = flag_q[FLG_TO];
                dq2 = tog_q[TOG_ERS];
                ready_n = 1'b0;
            end
            M_ERASE: begin
                dq6 = tog_q[TOG_BUSY];
                dq5 = flag_q[FLG_TO];
                dq3 = 1'b1;
                dq2 = tog_q[TOG_ERS];
                ready_n = 1'b0;
            end
            M_ESUSP: begin
                if (in_susp) begin
                    dq7 = 1'b1;
                    dq6 = tog_q[TOG_BUSY];
                    dq2 = tog_q[TOG_ERS];
                end else begin
                    array_sel = 1'b1;
                end
            end
            M_PSUSP: begin
                if (in_susp) begin
                    illegal_rd = 1'b1;
                end else begin
                    array_sel = 1'b1;
                end
            end
            M_ESPGM: begin
                dq7 = poll_n;
                dq6 = tog_q[TOG_BUSY];
                dq5 = flag_q[FLG_TO];
                ready_n = 1'b0;
            end
            M_WBUF: begin
                dq7 = poll_n;
                dq6 = tog_q[TOG_BUSY];
                dq5 = flag_q[FLG_TO];
                dq1 = flag_q[FLG_AB];
                ready_n = 1'b0;
            end
            default: begin
                array_sel = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/nor_status_gen.sv
// Top level of the embedded-operation status generator.
// Ties together the toggle flops, the sticky flags and the status decode.
// Assumes all inputs are synchronous to clk and the event inputs are one-cycle pulses.
module nor_status_gen
    import nsg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_mode,
    input  logic              in_susp_sector,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_strobe,
    input  logic              op_start,
    input  logic              timeout_evt,
    input  logic              abort_evt,
    input  logic              flag_clr,
    output logic              st_dq7,
    output logic              st_dq6,
    output logic              st_dq5,
    output logic              st_dq3,
    output logic              st_dq2,
    output logic              st_dq1,
    output logic              array_sel,
    output logic              ready_n,
    output logic              illegal_rd
);

    localparam int POLL_BIT = (DATA_W > 7) ? 7 : DATA_W - 1;

    op_mode_e            mode;
    logic [NUM_TOG-1:0]  tog_en;
    logic [NUM_TOG-1:0]  tog_q;
    logic [NUM_FLAG-1:0] flag_set;
    logic [NUM_FLAG-1:0] flag_q;

    assign mode = op_mode_e'(op_mode);

    nsg_toggle #(.N(NUM_TOG)) u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (op_start),
        .rd_strobe (rd_strobe),
        .tog_en    (tog_en),
        .tog_q     (tog_q)
    );

    nsg_sticky #(.N(NUM_FLAG)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (flag_clr),
        .set    (flag_set),
        .flag_q (flag_q)
    );

    nsg_decode #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT)) u_dec (
        .mode        (mode),
        .in_susp     (in_susp_sector),
        .wr_data     (wr_data),
        .tog_q       (tog_q),
        .flag_q      (flag_q),
        .timeout_evt (timeout_evt),
        .abort_evt   (abort_evt),
        .tog_en      (tog_en),
        .flag_set    (flag_set),
        .dq7         (st_dq7),
        .dq6         (st_dq6),
        .dq5         (st_dq5),
        .dq3         (st_dq3),
        .dq2         (st_dq2),
        .dq1         (st_dq1),
        .array_sel   (array_sel),
        .ready_n     (ready_n),
        .illegal_rd  (illegal_rd)
    );

endmodule

// File: rtl/nsg_checker.sv
// Assertion checker for nor_status_gen, attached through bind.
// Observes the top-level ports only.
module nsg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op_mode,
    input logic       in_susp_sector,
    input logic       rd_strobe,
    input logic       op_start,
    input logic       flag_clr,
    input logic       st_dq7,
    input logic       st_dq6,
    input logic       st_dq5,
    input logic       st_dq3,
    input logic       st_dq2,
    input logic       st_dq1,
    input logic       array_sel,
    input logic       ready_n,
    input logic       illegal_rd
);

    logic busy;
    assign busy = (op_mode == 3'd1) || (op_mode == 3'd2) || (op_mode == 3'd5) || (op_mode == 3'd6);

    // R2: busy toggle steps on each read in program mode
    p_dq6_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !op_start && op_mode == 3'd1) |=> (op_mode != 3'd1) || (st_dq6 != $past(st_dq6)));

    // R3: erase toggle steps on each read in erase mode
    p_dq2_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !op_start && op_mode == 3'd2) |=> (op_mode != 3'd2) || (st_dq2 != $past(st_dq2)));

    // R4: busy toggle holds while reading the erase-suspended sector
    p_susp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_start && op_mode == 3'd3 && in_susp_sector)
        |=> !(op_mode == 3'd3 && in_susp_sector) || $stable(st_dq6));

    // R6: a busy mode always reports busy on the ready line
    p_busy_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready_n);

    // R7: abort bit only ever visible in buffered-write mode
    p_abort_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_dq1 |-> (op_mode == 3'd6));

    // R8: time-limit bit persists across busy cycles until cleared
    p_timeout_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_dq5 && !flag_clr) |=> !busy || st_dq5);

    // R9: start pulse leaves both toggles cleared
    p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !st_dq6 && !st_dq2);

    // R10: illegal read drives a quiet status word and no array data
    p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_rd |-> !array_sel && !st_dq7 && !st_dq6 && !st_dq5 && !st_dq3 && !st_dq2 && !st_dq1);

    // R5: array select and illegal flag never together, and array select means ready
    p_array_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        array_sel |-> ready_n && !illegal_rd);

endmodule

bind nor_status_gen nsg_checker u_nsg_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_mode        (op_mode),
    .in_susp_sector (in_susp_sector),
    .rd_strobe      (rd_strobe),
    .op_start       (op_start),
    .flag_clr       (flag_clr),
    .st_dq7         (st_dq7),
    .st_dq6         (st_dq6),
    .st_dq5         (st_dq5),
    .st_dq3         (st_dq3),
    .st_dq2         (st_dq2),
    .st_dq1         (st_dq1),
    .array_sel      (array_sel),
    .ready_n        (ready_n),
    .illegal_rd     (illegal_rd)
);

// File: tb/tb_nor_status_gen.sv
// Directed bench for nor_status_gen: one task per scenario.
module tb_nor_status_gen;

    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [2:0]        op_mode;
    logic              in_susp_sector;
    logic [DATA_W-1:0] wr_data;
    logic              rd_strobe, op_start, timeout_evt, abort_evt, flag_clr;
    logic              st_dq7, st_dq6, st_dq5, st_dq3, st_dq2, st_dq1;
    logic              array_sel, ready_n, illegal_rd;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    nor_status_gen #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .in_susp_sector(in_susp_sector),
        .wr_data(wr_data), .rd_strobe(rd_strobe), .op_start(op_start),
        .timeout_evt(timeout_evt), .abort_evt(abort_evt), .flag_clr(flag_clr),
        .st_dq7(st_dq7), .st_dq6(st_dq6), .st_dq5(st_dq5), .st_dq3(st_dq3),
        .st_dq2(st_dq2), .st_dq1(st_dq1), .array_sel(array_sel), .ready_n(ready_n),
        .illegal_rd(illegal_rd)
    );

    // Status word packed as {dq7,dq6,dq5,dq3,dq2,dq1,array_sel,ready_n,illegal_rd}
    function automatic logic [8:0] outs();
        return {st_dq7, st_dq6, st_dq5, st_dq3, st_dq2, st_dq1, array_sel, ready_n, illegal_rd};
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m, input logic s);
        @(negedge clk);
        op_mode = m; in_susp_sector = s;
        #1;
    endtask

    task automatic pulse_start();
        @(negedge clk); op_start = 1'b1;
        @(negedge clk); op_start = 1'b0;
        #1;
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset_r1();
        do_reset();
        set_mode(3'd0, 1'b0);
        chk("R1 reset/mode0", outs(), 9'b000000_110);
        set_mode(3'd7, 1'b1);
        chk("R1 mode7", outs(), 9'b000000_110);
    endtask

    task automatic t_program_r2();
        wr_data = 16'h0080;
        set_mode(3'd1, 1'b1);
        pulse_start();
        chk("R2 program first", outs(), 9'b000000_000);
        do_read();
        chk("R2 program after read1", outs(), 9'b010000_000);
        wr_data = 16'h0000;
        do_read();
        #1;
        chk("R2 program after read2 data0", outs(), 9'b100000_000);
        do_read();
        chk1("R2 dq2 no toggle", st_dq2, 1'b0);
        chk1("R2 dq6 toggled", st_dq6, 1'b1);
    endtask

    task automatic t_erase_r3();
        set_mode(3'd2, 1'b1);
        pulse_start();
        chk("R3 erase start", outs(), 9'b000100_000);
        do_read();
        chk("R3 erase read1", outs(), 9'b010110_000);
        do_read();
        chk("R3 erase read2", outs(), 9'b000100_000);
    endtask

    task automatic t_esusp_r4();
        set_mode(3'd2, 1'b1);
        pulse_start();
        do_read();  // busy toggle 1, erase toggle 1
        set_mode(3'd3, 1'b1);
        chk("R4 esusp entry", outs(), 9'b110010_010);
        do_read();
        chk("R4 esusp read1", outs(), 9'b110000_010);
        do_read();
        chk("R4 esusp read2", outs(), 9'b110010_010);
    endtask

    task automatic t_nonsusp_r5();
        set_mode(3'd3, 1'b0);
        chk("R5 esusp other sector", outs(), 9'b000000_110);
        set_mode(3'd4, 1'b0);
        chk("R5 psusp other sector", outs(), 9'b000000_110);
    endtask

    task automatic t_esp_wbuf_r6();
        wr_data = 16'h0000;
        set_mode(3'd5, 1'b1);
        pulse_start();
        chk("R6 esp start", outs(), 9'b100000_000);
        do_read();
        chk("R6 esp read", outs(), 9'b110000_000);
        wr_data = 16'h00FF;
        set_mode(3'd6, 1'b1);
        chk("R6 wbuf", outs(), 9'b010000_000);
        do_read();
        chk("R6 wbuf read", outs(), 9'b000000_000);
    endtask

    task automatic t_abort_r7();
        wr_data = 16'h00FF;
        set_mode(3'd1, 1'b1);
        @(negedge clk); abort_evt = 1'b1;
        @(negedge clk); abort_evt = 1'b0;
        set_mode(3'd6, 1'b1);
        chk1("R7 abort outside wbuf ignored", st_dq1, 1'b0);
        @(negedge clk); abort_evt = 1'b1;
        @(negedge clk); abort_evt = 1'b0;
        #1;
        chk1("R7 abort set", st_dq1, 1'b1);
        repeat (3) @(negedge clk);
        #1;
        chk1("R7 abort sticky", st_dq1, 1'b1);
        set_mode(3'd1, 1'b1);
        chk1("R7 abort hidden in program", st_dq1, 1'b0);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        set_mode(3'd6, 1'b1);
        chk1("R7 abort cleared", st_dq1, 1'b0);
    endtask

    task automatic t_timeout_r8();
        set_mode(3'd2, 1'b1);
        @(negedge clk); timeout_evt = 1'b1;
        @(negedge clk); timeout_evt = 1'b0;
        #1;
        chk1("R8 timeout set", st_dq5, 1'b1);
        set_mode(3'd5, 1'b1);
        chk1("R8 timeout sticky other busy mode", st_dq5, 1'b1);
        @(negedge clk); flag_clr = 1'b1; timeout_evt = 1'b1;
        @(negedge clk); flag_clr = 1'b0; timeout_evt = 1'b0;
        #1;
        chk1("R8 clear wins", st_dq5, 1'b0);
    endtask

    task automatic t_start_prio_r9();
        set_mode(3'd2, 1'b1);
        pulse_start();
        do_read();
        chk1("R9 pre dq6", st_dq6, 1'b1);
        @(negedge clk); op_start = 1'b1; rd_strobe = 1'b1;
        @(negedge clk); op_start = 1'b0; rd_strobe = 1'b0;
        #1;
        chk("R9 start beats read", outs(), 9'b000100_000);
    endtask

    task automatic t_illegal_r10();
        set_mode(3'd2, 1'b1);
        pulse_start();
        do_read();
        set_mode(3'd4, 1'b1);
        chk("R10 illegal read", outs(), 9'b000000_011);
    endtask

    task automatic t_rst_r11();
        set_mode(3'd6, 1'b1);
        pulse_start();
        @(negedge clk); timeout_evt = 1'b1; abort_evt = 1'b1;
        @(negedge clk); timeout_evt = 1'b0; abort_evt = 1'b0;
        do_read();
        #1;
        chk1("R11 pre dq5", st_dq5, 1'b1);
        do_reset();
        chk("R11 flags and toggles cleared", outs(), {1'b0, 8'b00000_000});
    endtask

    initial begin
        rst_n = 1'b0; op_mode = 3'd0; in_susp_sector = 1'b0; wr_data = '0;
        rd_strobe = 1'b0; op_start = 1'b0; timeout_evt = 1'b0; abort_evt = 1'b0; flag_clr = 1'b0;
        t_reset_r1();
        t_program_r2();
        t_erase_r3();
        t_esusp_r4();
        t_nonsusp_r5();
        t_esp_wbuf_r6();
        t_abort_r7();
        t_timeout_r8();
        t_start_prio_r9();
        t_illegal_r10();
        t_rst_r11();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule